// File: doc/BRIEF.md
# Dual-Lane Min-Sum Layer Processor

This block carries out the check-node half of one layer of a layered min-sum LDPC decoder. It processes Z parity rows side by side, one vector element per row. Each beat delivers two sub-blocks of the current block row through two lanes, A and B. For each sub-block the beat carries an a-posteriori LLR vector and the check-to-variable vector stored for it on the previous pass. Each lane forms variable-to-check messages. It keeps a running smallest magnitude, second-smallest magnitude, position of the smallest and sign parity for every row element.

When the row-end beat has been taken, a merge step joins the two lane summaries into one result per row element. The block then replays every sub-block of the row, one per cycle, in arrival order. For each it emits the new check-to-variable vector and the updated LLR vector. Input is refused from the row-end beat until the last sub-block has left. The next layer, which may read LLRs this one is about to write, therefore cannot enter early. The cyclic shifters, message memories and matrix sequencing stay outside.

The controller has three states:
- GATHER accepts beats.
- MERGE joins the two lane summaries and lasts one cycle.
- EMIT outputs the sub-blocks.

The transitions are:
- GATHER→MERGE on an accepted beat flagged row-end.
- MERGE→EMIT unconditionally.
- EMIT→GATHER after the final sub-block.

Top module: `msum_dual_row`

## Requirements
- R1: Vector element z of every LLR and message bus sits at bits [z*W +: W] as a two's-complement value. Each variable-to-check value is the input LLR minus the stored check-to-variable value, clamped to the symmetric range ±(2^(W-1)-1).
- R2: The magnitude of each output check-to-variable element is the smallest variable-to-check magnitude among the other sub-blocks of the same row and element. For a row with a single sub-block it is 2^(W-1)-1.
- R3: An output check-to-variable element is negative when an odd number of the other sub-blocks' variable-to-check values for that element are negative.
- R4: Each output LLR element is the sub-block's variable-to-check value plus its new check-to-variable value, clamped to ±(2^(W-1)-1). The value -2^(W-1) never appears on any output.
- R5: A beat with in_pair_b low uses lane A only, and the data on lane B has no effect on any output. This lets a row with an odd number of sub-blocks finish with one half-filled beat.
- R6: Sub-block numbering and output timing:
  - Lane A of the k-th beat of a row is sub-block 2k and lane B is sub-block 2k+1. The row-end beat's edge is followed by one cycle without output.
  - Then come n consecutive cycles with out_valid high and out_idx running 0 to n-1. out_last is high only on the final one.
- R7: in_ready is high while the block is gathering. It is low from the cycle after the row-end beat until the last output has left. Beats offered while it is low have no effect.
- R8: After reset in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | beat offered |
| in_ready | output | 1 | beat accepted when both high |
| in_first | input | 1 | beat is the first of a row |
| in_last | input | 1 | beat is the last of a row |
| in_pair_b | input | 1 | lane B carries a sub-block |
| in_llr_a | input | Z*W | LLR vector, lane A |
| in_c2v_a | input | Z*W | stored check-to-variable vector, lane A |
| in_llr_b | input | Z*W | LLR vector, lane B |
| in_c2v_b | input | Z*W | stored check-to-variable vector, lane B |
| out_valid | output | 1 | output sub-block present |
| out_last | output | 1 | final sub-block of the row |
| out_idx | output | log2(MAXB) | sub-block number |
| out_c2v | output | Z*W | new check-to-variable vector |
| out_llr | output | Z*W | updated LLR vector |

## Verification
The hardest case is the merge of two lane summaries whose smallest magnitudes lie in different lanes or tie exactly. It only becomes visible when the second-smallest value comes from the other lane at the argmin position. Random rows of every length from 1 to 16 with full-range LLRs produce these splits across 42 independent elements per beat. Directed rows add all-equal saturated magnitudes and odd lengths with garbage on the idle lane B. Junk beats are offered during every stall to show they are dropped.

// File: rtl/msdr_pkg.sv
package msdr_pkg;

    typedef enum logic [1:0] {
        ST_GATHER = 2'd0,
        ST_MERGE  = 2'd1,
        ST_EMIT   = 2'd2
    } row_state_e;

    function automatic int clamp_sym(input int v, input int lim);
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

endpackage

// File: rtl/msdr_lane.sv
module msdr_lane
    import msdr_pkg::*;
#(
    parameter int Z    = 42,
    parameter int W    = 8,
    parameter int IDXW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clear,
    input  logic              present,
    input  logic [IDXW-1:0]   idx,
    input  logic [Z*W-1:0]    llr,
    input  logic [Z*W-1:0]    c2v,
    output logic [Z*W-1:0]    v2c,
    output logic [Z*(W-1)-1:0] m1_o,
    output logic [Z*(W-1)-1:0] m2_o,
    output logic [Z*IDXW-1:0] ix_o,
    output logic [Z-1:0]      par_o
);
    localparam int MW  = W - 1;
    localparam int LIM = (1 << (W - 1)) - 1;

    for (genvar z = 0; z < Z; z++) begin : g_el
        logic signed [W-1:0] l_s, c_s, v_s, a_s;
        logic [MW-1:0]       mag, b1, b2, m1_q, m2_q;
        logic [IDXW-1:0]     bix, ix_q;
        logic                sgn, bpar, par_q;

        always_comb begin
            l_s  = llr[z*W +: W];
            c_s  = c2v[z*W +: W];
            v_s  = W'(clamp_sym(int'(l_s) - int'(c_s), LIM));
            a_s  = v_s[W-1] ? -v_s : v_s;
            mag  = present ? a_s[MW-1:0] : '1;
            sgn  = present & v_s[W-1];
            b1   = clear ? '1 : m1_q;
            b2   = clear ? '1 : m2_q;
            bix  = clear ? '0 : ix_q;
            bpar = clear ? 1'b0 : par_q;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m1_q  <= '1;
                m2_q  <= '1;
                ix_q  <= '0;
                par_q <= 1'b0;
            end else if (en) begin
                if (mag < b1) begin
                    m1_q <= mag;
                    m2_q <= b1;
                    ix_q <= idx;
                end else begin
                    m1_q <= b1;
                    m2_q <= (mag < b2) ? mag : b2;
                    ix_q <= bix;
                end
                par_q <= bpar ^ sgn;
            end
        end

        assign v2c[z*W +: W]     = v_s;
        assign m1_o[z*MW +: MW]  = m1_q;
        assign m2_o[z*MW +: MW]  = m2_q;
        assign ix_o[z*IDXW +: IDXW] = ix_q;
        assign par_o[z]          = par_q;
    end
endmodule

// File: rtl/msdr_merge.sv
module msdr_merge #(
    parameter int Z    = 42,
    parameter int W    = 8,
    parameter int IDXW = 4
) (
    input  logic [Z*(W-1)-1:0] a_m1,
    input  logic [Z*(W-1)-1:0] a_m2,
    input  logic [Z*IDXW-1:0]  a_ix,
    input  logic [Z-1:0]       a_par,
    input  logic [Z*(W-1)-1:0] b_m1,
    input  logic [Z*(W-1)-1:0] b_m2,
    input  logic [Z*IDXW-1:0]  b_ix,
    input  logic [Z-1:0]       b_par,
    output logic [Z*(W-1)-1:0] m1,
    output logic [Z*(W-1)-1:0] m2,
    output logic [Z*IDXW-1:0]  ix,
    output logic [Z-1:0]       par
);
    localparam int MW = W - 1;

    for (genvar z = 0; z < Z; z++) begin : g_el
        logic [MW-1:0] am1, am2, bm1, bm2;
        always_comb begin
            am1 = a_m1[z*MW +: MW];
            am2 = a_m2[z*MW +: MW];
            bm1 = b_m1[z*MW +: MW];
            bm2 = b_m2[z*MW +: MW];
            if (bm1 < am1) begin
                m1[z*MW +: MW]       = bm1;
                m2[z*MW +: MW]       = (am1 < bm2) ? am1 : bm2;
                ix[z*IDXW +: IDXW]   = b_ix[z*IDXW +: IDXW];
            end else begin
                m1[z*MW +: MW]       = am1;
                m2[z*MW +: MW]       = (bm1 < am2) ? bm1 : am2;
                ix[z*IDXW +: IDXW]   = a_ix[z*IDXW +: IDXW];
            end
            par[z] = a_par[z] ^ b_par[z];
        end
    end
endmodule

// File: rtl/msum_dual_row.sv
module msum_dual_row
    import msdr_pkg::*;
#(
    parameter int Z    = 42,
    parameter int W    = 8,
    parameter int MAXB = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        in_first,
    input  logic                        in_last,
    input  logic                        in_pair_b,
    input  logic [Z*W-1:0]              in_llr_a,
    input  logic [Z*W-1:0]              in_c2v_a,
    input  logic [Z*W-1:0]              in_llr_b,
    input  logic [Z*W-1:0]              in_c2v_b,
    output logic                        out_valid,
    output logic                        out_last,
    output logic [$clog2(MAXB)-1:0]     out_idx,
    output logic [Z*W-1:0]              out_c2v,
    output logic [Z*W-1:0]              out_llr
);
    localparam int IDXW  = $clog2(MAXB);
    localparam int PAIRS = MAXB / 2;
    localparam int PW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam int MW    = W - 1;
    localparam int VW    = Z * W;
    localparam int LIM   = (1 << (W - 1)) - 1;

    row_state_e        state_q, state_d;
    logic              accept;
    logic [PW-1:0]     pair_q, cur_pair;
    logic [IDXW-1:0]   idx_a, idx_b, last_q, emit_q;
    logic [VW-1:0]     v2c_a, v2c_b;
    logic [VW-1:0]     vbuf [MAXB];

    logic [Z*MW-1:0]   a_m1, a_m2, b_m1, b_m2, c_m1, c_m2, r_m1, r_m2;
    logic [Z*IDXW-1:0] a_ix, b_ix, c_ix, r_ix;
    logic [Z-1:0]      a_par, b_par, c_par, r_par;

    assign accept   = in_valid & in_ready;
    assign cur_pair = in_first ? '0 : pair_q;
    assign idx_a    = IDXW'({cur_pair, 1'b0});
    assign idx_b    = IDXW'({cur_pair, 1'b1});

    msdr_lane #(.Z(Z), .W(W), .IDXW(IDXW)) u_lane_a (
        .clk(clk), .rst_n(rst_n), .en(accept), .clear(in_first),
        .present(1'b1), .idx(idx_a), .llr(in_llr_a), .c2v(in_c2v_a),
        .v2c(v2c_a), .m1_o(a_m1), .m2_o(a_m2), .ix_o(a_ix), .par_o(a_par)
    );

    msdr_lane #(.Z(Z), .W(W), .IDXW(IDXW)) u_lane_b (
        .clk(clk), .rst_n(rst_n), .en(accept), .clear(in_first),
        .present(in_pair_b), .idx(idx_b), .llr(in_llr_b), .c2v(in_c2v_b),
        .v2c(v2c_b), .m1_o(b_m1), .m2_o(b_m2), .ix_o(b_ix), .par_o(b_par)
    );

    msdr_merge #(.Z(Z), .W(W), .IDXW(IDXW)) u_merge (
        .a_m1(a_m1), .a_m2(a_m2), .a_ix(a_ix), .a_par(a_par),
        .b_m1(b_m1), .b_m2(b_m2), .b_ix(b_ix), .b_par(b_par),
        .m1(c_m1), .m2(c_m2), .ix(c_ix), .par(c_par)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_GATHER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATHER: if (accept && in_last) state_d = ST_MERGE;
            ST_MERGE:  state_d = ST_EMIT;
            ST_EMIT:   if (emit_q == last_q) state_d = ST_GATHER;
            default:   state_d = ST_GATHER;
        endcase
    end

    // counters and merged row summary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0;
            last_q <= '0;
            emit_q <= '0;
            r_m1   <= '1;
            r_m2   <= '1;
            r_ix   <= '0;
            r_par  <= '0;
        end else begin
            if (accept) begin
                pair_q <= in_last ? '0 : cur_pair + 1'b1;
                if (in_last) last_q <= in_pair_b ? idx_b : idx_a;
            end
            if (state_q == ST_MERGE) begin
                r_m1  <= c_m1;
                r_m2  <= c_m2;
                r_ix  <= c_ix;
                r_par <= c_par;
            end
            if (state_q == ST_EMIT)
                emit_q <= (emit_q == last_q) ? '0 : emit_q + 1'b1;
        end
    end

    // variable-to-check store for the output pass
    always_ff @(posedge clk) begin
        if (accept) begin
            vbuf[idx_a] <= v2c_a;
            if (in_pair_b) vbuf[idx_b] <= v2c_b;
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_GATHER);
        out_valid = (state_q == ST_EMIT);
        out_last  = (state_q == ST_EMIT) && (emit_q == last_q);
        out_idx   = emit_q;
    end

    for (genvar z = 0; z < Z; z++) begin : g_out
        logic signed [W-1:0] v_s;
        logic [MW-1:0]       mag;
        logic                sgn;
        int                  cm;
        always_comb begin
            v_s = vbuf[emit_q][z*W +: W];
            mag = (r_ix[z*IDXW +: IDXW] == emit_q) ? r_m2[z*MW +: MW]
                                                   : r_m1[z*MW +: MW];
            sgn = r_par[z] ^ v_s[W-1];
            cm  = sgn ? -int'(mag) : int'(mag);
            out_c2v[z*W +: W] = W'(cm);
            out_llr[z*W +: W] = W'(clamp_sym(int'(v_s) + cm, LIM));
        end
    end
endmodule

// File: rtl/msum_dual_row_chk.sv
module msum_dual_row_chk #(
    parameter int Z    = 42,
    parameter int W    = 8,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            in_last,
    input logic            out_valid,
    input logic            out_last,
    input logic [IDXW-1:0] out_idx,
    input logic [Z*W-1:0]  out_c2v,
    input logic [Z*W-1:0]  out_llr
);
    logic bad_val;
    always_comb begin
        bad_val = 1'b0;
        for (int z = 0; z < Z; z++) begin
            if (out_llr[z*W +: W] == {1'b1, {(W-1){1'b0}}}) bad_val = 1'b1;
            if (out_c2v[z*W +: W] == {1'b1, {(W-1){1'b0}}}) bad_val = 1'b1;
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !bad_val);

    // R7
    stall_while_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R7
    stall_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> (!in_ready && !out_valid));

    // R6
    first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_idx == '0));

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

    // R6
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (!out_valid && in_ready));
endmodule

bind msum_dual_row msum_dual_row_chk #(.Z(Z), .W(W), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .out_valid(out_valid), .out_last(out_last),
    .out_idx(out_idx), .out_c2v(out_c2v), .out_llr(out_llr)
);

// File: tb/msum_dual_row_tb.sv
module msum_dual_row_tb;
    localparam int Z    = 42;
    localparam int W    = 8;
    localparam int MAXB = 16;
    localparam int IDXW = 4;
    localparam int LIM  = 127;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_pair_b = 1'b0;
    logic in_ready;
    logic [Z*W-1:0] in_llr_a = '0, in_c2v_a = '0, in_llr_b = '0, in_c2v_b = '0;
    logic out_valid, out_last;
    logic [IDXW-1:0] out_idx;
    logic [Z*W-1:0] out_c2v, out_llr;

    int n_tests = 0;
    int n_fail  = 0;
    int llr_m [MAXB][Z];
    int c2v_m [MAXB][Z];

    always #5 clk = ~clk;

    msum_dual_row #(.Z(Z), .W(W), .MAXB(MAXB)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_first(in_first), .in_last(in_last), .in_pair_b(in_pair_b),
        .in_llr_a(in_llr_a), .in_c2v_a(in_c2v_a), .in_llr_b(in_llr_b),
        .in_c2v_b(in_c2v_b), .out_valid(out_valid), .out_last(out_last),
        .out_idx(out_idx), .out_c2v(out_c2v), .out_llr(out_llr)
    );

    function automatic int clampi(int v);
        if (v > LIM)  return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    function automatic int rnd8();
        return int'($urandom_range(0, 255)) - 128;
    endfunction

    function automatic logic [Z*W-1:0] rnd_vec();
        logic [Z*W-1:0] r;
        for (int z = 0; z < Z; z++) r[z*W +: W] = W'(rnd8());
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [Z*W-1:0] act, input logic [Z*W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_row(input int n, input bit junk);
        int v [MAXB][Z];
        logic [Z*W-1:0] ec [MAXB];
        logic [Z*W-1:0] el [MAXB];
        int pairs;
        for (int i = 0; i < n; i++)
            for (int z = 0; z < Z; z++) v[i][z] = clampi(llr_m[i][z] - c2v_m[i][z]); // R1
        for (int i = 0; i < n; i++) begin
            for (int z = 0; z < Z; z++) begin
                int m = LIM;
                bit p = 1'b0;
                int c;
                for (int j = 0; j < n; j++) begin
                    if (j == i) continue;
                    if ((v[j][z] < 0 ? -v[j][z] : v[j][z]) < m) m = (v[j][z] < 0 ? -v[j][z] : v[j][z]); // R2
                    p ^= (v[j][z] < 0);                                                               // R3
                end
                c = p ? -m : m;
                ec[i][z*W +: W] = W'(c);
                el[i][z*W +: W] = W'(clampi(v[i][z] + c)); // R4
            end
        end
        pairs = (n + 1) / 2;
        for (int p = 0; p < pairs; p++) begin
            @(negedge clk);
            check(in_ready == 1'b1, "R7", "in_ready gather", {{(Z*W-1){1'b0}}, in_ready}, 1);
            in_valid  = 1'b1;
            in_first  = (p == 0);
            in_last   = (p == pairs - 1);
            in_pair_b = (2*p + 1 < n);
            for (int z = 0; z < Z; z++) begin
                in_llr_a[z*W +: W] = W'(llr_m[2*p][z]);
                in_c2v_a[z*W +: W] = W'(c2v_m[2*p][z]);
            end
            if (in_pair_b) begin
                for (int z = 0; z < Z; z++) begin
                    in_llr_b[z*W +: W] = W'(llr_m[2*p+1][z]);
                    in_c2v_b[z*W +: W] = W'(c2v_m[2*p+1][z]);
                end
            end else begin
                in_llr_b = rnd_vec(); // R5: garbage on the idle lane
                in_c2v_b = rnd_vec();
            end
        end
        @(negedge clk);
        check(!out_valid && !in_ready, "R6", "merge gap", {{(Z*W-2){1'b0}}, out_valid, in_ready}, 0);
        in_valid = junk;
        if (junk) begin // R7: offered beats while stalled
            in_first = 1'b1; in_last = 1'b1; in_pair_b = 1'b1;
            in_llr_a = rnd_vec(); in_c2v_a = rnd_vec();
            in_llr_b = rnd_vec(); in_c2v_b = rnd_vec();
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(out_valid && !in_ready && out_idx == IDXW'(k) && out_last == (k == n - 1),
                  "R6", "valid/idx/last", {{(Z*W-7){1'b0}}, out_valid, in_ready, out_last, out_idx},
                  {{(Z*W-7){1'b0}}, 1'b1, 1'b0, (k == n - 1), IDXW'(k)});
            check(out_c2v == ec[k], "R2/R3", "c2v", out_c2v, ec[k]);
            check(out_llr == el[k], "R4", "llr", out_llr, el[k]);
            if (k == n - 1) in_valid = 1'b0;
        end
    endtask

    task automatic fill_rand(input int n);
        for (int i = 0; i < n; i++)
            for (int z = 0; z < Z; z++) begin
                llr_m[i][z] = rnd8();
                c2v_m[i][z] = rnd8();
            end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5c0de));
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R8", "reset state",
              {{(Z*W-2){1'b0}}, in_ready, out_valid}, 2);
        rst_n = 1'b1;

        // R2: single sub-block row, magnitude is the ceiling
        fill_rand(1);
        run_row(1, 1'b0);

        // R1 R4: saturated inputs, all magnitudes tie
        for (int i = 0; i < MAXB; i++)
            for (int z = 0; z < Z; z++) begin
                llr_m[i][z] = -128;
                c2v_m[i][z] = (z % 2) ? 127 : -128;
            end
        run_row(MAXB, 1'b1);

        // R5: odd row, lane B idle on the last beat
        fill_rand(5);
        run_row(5, 1'b1);

        // R2 R3: two sub-blocks with small equal magnitudes and mixed signs
        for (int z = 0; z < Z; z++) begin
            llr_m[0][z] = (z % 3) - 1; c2v_m[0][z] = 0;
            llr_m[1][z] = 1 - (z % 3); c2v_m[1][z] = 0;
        end
        run_row(2, 1'b0);

        // random rows of every length
        for (int r = 0; r < 48; r++) begin
            int n = int'($urandom_range(1, MAXB));
            fill_rand(n);
            run_row(n, r[0]);
        end

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule